// File: doc/BRIEF.md
# Ethernet PHY Management Register Bank

This block is the management register file of a 10/100 Ethernet transceiver, as a station manager sees it once the serial management frames have been decoded. The register number, write data and write strobe come in on a plain synchronous interface. The read data for the selected register is returned combinationally.

Most of the 32 registers are plain 16-bit storage. Three of them are computed on every read from the advertisement register, which is register 4:

- **Basic status (register 1)** reports a fixed capability set, with link up and auto-negotiation complete.
- **Link-partner ability (register 5)** echoes the advertised technology bits.
- **Diagnostics (register 18)** reports the speed and duplex that the host's best advertised mode resolves to.

Because of this, negotiation always succeeds with whatever the host offers. The resolved speed and duplex also leave the block as pins. A registered flag compares the resolved duplex with the duplex the MAC is configured for, and updates only while the MAC is enabled.

Top module: `phy_mgmt_regbank`

## Requirements
- R1: After synchronous reset, the registers read as follows: register 0 = 0x3100, register 2 = 0x0300, register 3 = 0xE400, register 4 = 0x01E1, and every other stored register (for example 7, 31) = 0x0000.
- R2: A read of register 1 always returns 0x782C. This value has bits 14, 13, 12, 11, 5, 3 and 2 set.
- R3: A read of register 5 returns 0x4001 OR (register 4 AND 0x01E0). That is bit 14 set, bit 0 set, and bits 8:5 copied from register 4 bits 8:5.
- R4: A read of register 18 returns bit 10 = register4[7] OR register4[8], and bit 11 = register4[6] OR register4[8]. All other bits are 0.
- R5: When wr_en is high at a rising clock edge, wr_data is stored into the selected register. A register that is not computed then returns that value on rd_data from the next cycle on. Reads are combinational from the current state.
- R6: Writes to registers 1, 5 and 18 have no effect on what those registers return.
- R7: speed_100 equals register 18 bit 10 and full_duplex equals register 18 bit 11, at all times.
- R8: duplex_mismatch is 0 after reset. At each rising edge where mac_enable is high, it takes full_duplex XOR mac_full_duplex. While mac_enable is low it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 5 | Register number for both read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| speed_100 | output | 1 | Resolved speed is 100 Mb/s |
| full_duplex | output | 1 | Resolved duplex is full |
| mac_full_duplex | input | 1 | Duplex setting of the attached MAC |
| mac_enable | input | 1 | MAC enabled; gates mismatch flag updates |
| duplex_mismatch | output | 1 | Registered duplex disagreement flag |

## Verification
The write-back property assumes that reg_sel is held across the write edge and the following read cycle. The bench's write task honours this by keeping the selector stable from the falling edge before the write until after the read-back sample.

The mismatch properties assume that mac_enable and mac_full_duplex change only away from the rising edge. The bench therefore moves every input on the falling edge.

The properties also assume that no input is X after reset. The bench drives every input to a known value from time zero.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int NUM_REGS  = 32;
    localparam int DATA_W    = 16;
    localparam int IDX_W     = $clog2(NUM_REGS);

    localparam int IDX_CTRL    = 0;
    localparam int IDX_STATUS  = 1;
    localparam int IDX_ID_HI   = 2;
    localparam int IDX_ID_LO   = 3;
    localparam int IDX_ADV     = 4;
    localparam int IDX_PARTNER = 5;
    localparam int IDX_DIAG    = 18;

    localparam logic [DATA_W-1:0] STATUS_CONST  = 16'h782C;
    localparam logic [DATA_W-1:0] PARTNER_FIXED = 16'h4001;
    localparam logic [DATA_W-1:0] TECH_MASK     = 16'h01E0;

    localparam int ADV_10_FD  = 6;
    localparam int ADV_100_HD = 7;
    localparam int ADV_100_FD = 8;
    localparam int DIAG_SPEED = 10;
    localparam int DIAG_DUPLX = 11;

    typedef struct packed {
        logic spd100;
        logic fdx;
    } resolved_mode_t;

    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        case (idx)
            IDX_CTRL:  return 16'h3100;
            IDX_ID_HI: return 16'h0300;
            IDX_ID_LO: return 16'hE400;
            IDX_ADV:   return 16'h01E1;
            default:   return '0;
        endcase
    endfunction

    function automatic logic is_synth(input logic [IDX_W-1:0] idx);
        return (idx == IDX_W'(IDX_STATUS)) || (idx == IDX_W'(IDX_PARTNER)) ||
               (idx == IDX_W'(IDX_DIAG));
    endfunction

    function automatic resolved_mode_t resolve(input logic [DATA_W-1:0] adv);
        resolved_mode_t m;
        m.spd100 = adv[ADV_100_HD] | adv[ADV_100_FD];
        m.fdx    = adv[ADV_10_FD]  | adv[ADV_100_FD];
        return m;
    endfunction

endpackage

// File: rtl/phy_reg_store.sv
module phy_reg_store
    import phy_mgmt_pkg::*;
#(
    parameter int N = NUM_REGS,
    parameter int W = DATA_W,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] idx,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  stored,
    output logic [W-1:0]  adv
);
    logic [W-1:0] cells [N];

    for (genvar g = 0; g < N; g++) begin : g_cell
        localparam logic [W-1:0] RV = W'(reset_value(g));
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= RV;
            else if (we && idx == IW'(g))
                cells[g] <= wdata;
        end
    end

    assign stored = cells[idx];
    assign adv    = cells[IDX_ADV];
endmodule

// File: rtl/phy_read_view.sv
module phy_read_view
    import phy_mgmt_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] stored,
    input  logic [DATA_W-1:0] adv,
    output logic [DATA_W-1:0] rdata,
    output resolved_mode_t    mode
);
    logic [DATA_W-1:0] diag_word;

    always_comb begin
        mode = resolve(adv);
        diag_word = '0;
        diag_word[DIAG_SPEED] = mode.spd100;
        diag_word[DIAG_DUPLX] = mode.fdx;
    end

    always_comb begin
        case (idx)
            IDX_W'(IDX_STATUS):  rdata = STATUS_CONST;
            IDX_W'(IDX_PARTNER): rdata = PARTNER_FIXED | (adv & TECH_MASK);
            IDX_W'(IDX_DIAG):    rdata = diag_word;
            default:             rdata = stored;
        endcase
    end
endmodule

// File: rtl/duplex_guard.sv
module duplex_guard (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic phy_fdx,
    input  logic mac_fdx,
    output logic mismatch
);
    always_ff @(posedge clk) begin
        if (rst)
            mismatch <= 1'b0;
        else if (enable)
            mismatch <= phy_fdx ^ mac_fdx;
    end
endmodule

// File: rtl/phy_mgmt_regbank.sv
module phy_mgmt_regbank
    import phy_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              speed_100,
    output logic              full_duplex,
    input  logic              mac_full_duplex,
    input  logic              mac_enable,
    output logic              duplex_mismatch
);
    logic [DATA_W-1:0] stored_q;
    logic [DATA_W-1:0] adv_q;
    resolved_mode_t    mode;

    phy_reg_store #(.N(NUM_REGS), .W(DATA_W)) i_store (
        .clk    (clk),
        .rst    (rst),
        .idx    (reg_sel),
        .we     (wr_en),
        .wdata  (wr_data),
        .stored (stored_q),
        .adv    (adv_q)
    );

    phy_read_view i_view (
        .idx    (reg_sel),
        .stored (stored_q),
        .adv    (adv_q),
        .rdata  (rd_data),
        .mode   (mode)
    );

    assign speed_100   = mode.spd100;
    assign full_duplex = mode.fdx;

    duplex_guard i_guard (
        .clk      (clk),
        .rst      (rst),
        .enable   (mac_enable),
        .phy_fdx  (mode.fdx),
        .mac_fdx  (mac_full_duplex),
        .mismatch (duplex_mismatch)
    );
endmodule

// File: rtl/phy_mgmt_regbank_chk.sv
module phy_mgmt_regbank_chk
    import phy_mgmt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [IDX_W-1:0]  reg_sel,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              speed_100,
    input logic              full_duplex,
    input logic              mac_full_duplex,
    input logic              mac_enable,
    input logic              duplex_mismatch
);
    // R2
    status_const_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == IDX_W'(IDX_STATUS)) |-> (rd_data == 16'h782C));

    // R7
    diag_pins_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == IDX_W'(IDX_DIAG)) |->
            (rd_data[10] == speed_100 && rd_data[11] == full_duplex));

    // R3
    partner_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == IDX_W'(IDX_PARTNER)) |->
            (rd_data[14] && rd_data[0] && rd_data[4:1] == 4'h0));

    // R5
    write_back_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && reg_sel == $past(reg_sel) && !is_synth(reg_sel))
            |-> (rd_data == $past(wr_data)));

    // R8
    mismatch_upd_chk: assert property (@(posedge clk) disable iff (rst)
        mac_enable |=> (duplex_mismatch == $past(full_duplex ^ mac_full_duplex)));

    // R8
    mismatch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mac_enable |=> $stable(duplex_mismatch));
endmodule

bind phy_mgmt_regbank phy_mgmt_regbank_chk i_chk (.*);

// File: tb/test_phy_mgmt_regbank.sv
module test_phy_mgmt_regbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_sel = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        speed_100, full_duplex, duplex_mismatch;
    logic        mac_full_duplex = 1'b0;
    logic        mac_enable = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    phy_mgmt_regbank i_phy_mgmt_regbank (.*);

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic rd(input int r, output logic [15:0] v);
        @(negedge clk);
        reg_sel = 5'(r);
        #1 v = rd_data;
    endtask

    task automatic wr(input int r, input logic [15:0] d);
        @(negedge clk);
        reg_sel = 5'(r); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset_values();
        logic [15:0] v;
        rd(0, v);  check("R1 reg0", v, 16'h3100);
        rd(2, v);  check("R1 reg2", v, 16'h0300);
        rd(3, v);  check("R1 reg3", v, 16'hE400);
        rd(4, v);  check("R1 reg4", v, 16'h01E1);
        rd(7, v);  check("R1 reg7", v, 16'h0000);
        rd(31, v); check("R1 reg31", v, 16'h0000);
        check("R8 reset flag", 16'(duplex_mismatch), 16'h0);
    endtask

    task automatic t_computed(input logic [15:0] adv, input logic [15:0] exp5,
                              input logic [15:0] exp18);
        logic [15:0] v;
        wr(4, adv);
        rd(1, v);  check("R2 status", v, 16'h782C);
        rd(5, v);  check("R3 partner", v, exp5);
        rd(18, v); check("R4 diag", v, exp18);
        check("R7 speed pin", 16'(speed_100), 16'(exp18[10]));
        check("R7 duplex pin", 16'(full_duplex), 16'(exp18[11]));
    endtask

    task automatic t_plain_write();
        logic [15:0] v;
        wr(9, 16'hA5C3);  rd(9, v);  check("R5 reg9", v, 16'hA5C3);
        wr(31, 16'h1234); rd(31, v); check("R5 reg31", v, 16'h1234);
        wr(0, 16'h0000);  rd(0, v);  check("R5 reg0", v, 16'h0000);
        rd(9, v); check("R5 reg9 kept", v, 16'hA5C3);
    endtask

    task automatic t_synth_ignore();
        logic [15:0] v;
        wr(4, 16'h0021);
        wr(1, 16'h0000);  rd(1, v);  check("R6 reg1", v, 16'h782C);
        wr(5, 16'hFFFF);  rd(5, v);  check("R6 reg5", v, 16'h4021);
        wr(18, 16'hFFFF); rd(18, v); check("R6 reg18", v, 16'h0000);
    endtask

    task automatic t_mismatch();
        wr(4, 16'h01E1);
        @(negedge clk); mac_full_duplex = 1'b0; mac_enable = 1'b1;
        @(negedge clk); check("R8 set", 16'(duplex_mismatch), 16'h1);
        mac_enable = 1'b0; mac_full_duplex = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R8 hold", 16'(duplex_mismatch), 16'h1);
        wr(4, 16'h0021);
        check("R8 hold adv change", 16'(duplex_mismatch), 16'h1);
        mac_enable = 1'b1;
        @(negedge clk); check("R8 half vs full", 16'(duplex_mismatch), 16'h1);
        mac_full_duplex = 1'b0;
        @(negedge clk); check("R8 clear", 16'(duplex_mismatch), 16'h0);
        mac_enable = 1'b0;
    endtask

    task automatic t_reset_again();
        logic [15:0] v;
        wr(9, 16'h5555);
        @(negedge clk); mac_enable = 1'b1; mac_full_duplex = 1'b1;
        wr(4, 16'h0021);
        @(negedge clk); mac_enable = 1'b0;
        do_reset();
        rd(9, v); check("R1 reg9 cleared", v, 16'h0000);
        rd(4, v); check("R1 reg4 restored", v, 16'h01E1);
        check("R8 flag cleared", 16'(duplex_mismatch), 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_values();
        t_computed(16'h01E1, 16'h41E1, 16'h0C00);
        t_computed(16'h0021, 16'h4021, 16'h0000);
        t_computed(16'h0041, 16'h4041, 16'h0800);
        t_computed(16'h0081, 16'h4081, 16'h0400);
        t_computed(16'hFE1F, 16'h4001, 16'h0000);
        t_plain_write();
        t_synth_ignore();
        t_mismatch();
        t_reset_again();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule